// File: doc/BRIEF.md
# Six-Channel Shadow-Buffered PWM Generator

This block produces six independent pulse-width-modulated outputs. A plain 32-bit register port configures them. Each channel owns a control word, a period count and a duty count, all measured in cycles of the block clock. Software first writes new period and duty values into shadow storage. It then requests an update. The free-running counter picks up the shadowed values only at the clock edge that ends the current period, so no period on the pin is ever made from two configurations.

Each channel runs a two-state machine. In `CH_IDLE` the counter is held at zero and the pin is low. The transition *arm* (`CH_IDLE` to `CH_RUN`) happens on a control write with the start bit set. In `CH_RUN` the counter wraps at the end of each period. The only transition out of `CH_RUN` is *hold* (`CH_RUN` to `CH_RUN`); only reset returns a channel to `CH_IDLE`. To turn a channel off, software commits a duty of zero. The polarity bit decides which comes first in each period: a high phase of duty length, or a low phase of duty length.

Top module: `pwm_bank`

## Requirements
- R1: After reset every output is low, every channel is in `CH_IDLE`, and every register reads zero.
- R2: Channel n occupies byte addresses n*0x20 upward. Within a channel, control is at offset 0x00, period at 0x08 and duty at 0x0C. Control bits are start=0, update=2, continuous=3+2=5 and polarity=8. Period and duty read back their shadow values. Any other address reads zero, and a write to it changes nothing.
- R3: The update bit reads 1 from the write that sets it until the commit. A channel in `CH_IDLE` commits on the next clock edge after the request.
- R4: A running channel copies its shadow period, duty and polarity only at the edge where the counter leaves period-1. Shadow writes with no update request leave the output untouched.
- R5: With polarity 1 the output is high while counter < duty and low afterwards. With polarity 0 it is low while counter < duty and high afterwards.
- R6: A committed duty of 0 holds the output low under either polarity.
- R7: A duty of at least the period keeps the duty phase active for the whole period. A period of 0 behaves as a period of 1.
- R8: The *arm* transition starts counting from 0 on the following edge, with the committed values. Start is set-only, so a control write with bit 0 clear does not stop a running channel.
- R9: If an update request lands on the commit edge, the update bit stays pending. A later boundary then commits the shadow contents as they stand at that later time.
- R10: Channels run independently of each other. The continuous bit is stored and read back but has no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; counters advance on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte address of the register being accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwm_out | output | 6 | One PWM output per channel |

## Verification
Two functions can fall in the same cycle: a control write that requests an update, and the period-boundary commit that clears the previous request. The bench times a second update request to land exactly on the wrap edge of a running channel, and changes the shadow duty to zero one cycle later. It then checks that the output drops to low at the next boundary, which can only happen if the pending request survived the collision. The same cycle-accurate waveform comparison also shows that shadow writes made in mid-period do not reach the pin early.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
    localparam int BUS_W      = 32;
    localparam int STRIDE_LG  = 5;
    localparam int BIT_START  = 0;
    localparam int BIT_UPDATE = 2;
    localparam int BIT_CONT   = 5;
    localparam int BIT_POL    = 8;

    localparam logic [STRIDE_LG-1:0] OFF_CTRL   = 5'h00;
    localparam logic [STRIDE_LG-1:0] OFF_PERIOD = 5'h08;
    localparam logic [STRIDE_LG-1:0] OFF_DUTY   = 5'h0C;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_CTRL,
        REG_PERIOD,
        REG_DUTY
    } reg_sel_e;

    typedef enum logic {
        CH_IDLE,
        CH_RUN
    } ch_state_e;
endpackage

// File: rtl/pwm_bank_decode.sv
module pwm_bank_decode
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] ch_hit,
    output reg_sel_e          sel
);
    localparam int IDX_W = ADDR_W - STRIDE_LG;

    logic [IDX_W-1:0] idx;
    assign idx = addr[ADDR_W-1:STRIDE_LG];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
        assign ch_hit[i] = (idx == IDX_W'(i));
    end

    always_comb begin
        unique case (addr[STRIDE_LG-1:0])
            OFF_CTRL:   sel = REG_CTRL;
            OFF_PERIOD: sel = REG_PERIOD;
            OFF_DUTY:   sel = REG_DUTY;
            default:    sel = REG_NONE;
        endcase
    end
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             pwm_o
);
    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, per_eff;
    logic [CNT_W-1:0] shd_per_q, shd_duty_q, act_per_q, act_duty_q;
    logic             shd_pol_q, act_pol_q, cont_q, pend_q;
    logic             ctrl_wr, upd_set, start_set, last, commit, phase;

    assign ctrl_wr   = wr_en && (sel == REG_CTRL);
    assign upd_set   = ctrl_wr && wdata[BIT_UPDATE];
    assign start_set = ctrl_wr && wdata[BIT_START];
    assign per_eff   = (act_per_q == '0) ? CNT_W'(1) : act_per_q;
    assign last      = (cnt_q == per_eff - CNT_W'(1));
    assign commit    = pend_q && ((state_q == CH_IDLE) || last);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // Next state: arm on start, hold once running
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (start_set) state_d = CH_RUN;
            CH_RUN:  state_d = CH_RUN;
        endcase
    end

    // Counter, shadow and working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            shd_per_q  <= '0;
            shd_duty_q <= '0;
            act_per_q  <= '0;
            act_duty_q <= '0;
            shd_pol_q  <= 1'b0;
            act_pol_q  <= 1'b0;
            cont_q     <= 1'b0;
            pend_q     <= 1'b0;
        end else begin
            if (state_q == CH_RUN) cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
            else                   cnt_q <= '0;
            if (commit) begin
                act_per_q  <= shd_per_q;
                act_duty_q <= shd_duty_q;
                act_pol_q  <= shd_pol_q;
            end
            if (upd_set)     pend_q <= 1'b1;
            else if (commit) pend_q <= 1'b0;
            if (ctrl_wr) begin
                cont_q    <= wdata[BIT_CONT];
                shd_pol_q <= wdata[BIT_POL];
            end
            if (wr_en && sel == REG_PERIOD) shd_per_q  <= wdata[CNT_W-1:0];
            if (wr_en && sel == REG_DUTY)   shd_duty_q <= wdata[CNT_W-1:0];
        end
    end

    // Outputs
    always_comb begin
        phase = (cnt_q < act_duty_q);
        pwm_o = 1'b0;
        unique case (state_q)
            CH_IDLE: pwm_o = 1'b0;
            CH_RUN:  pwm_o = (act_duty_q != '0) && (act_pol_q ? phase : !phase);
        endcase
        rdata = '0;
        unique case (sel)
            REG_CTRL: begin
                rdata[BIT_START]  = (state_q == CH_RUN);
                rdata[BIT_UPDATE] = pend_q;
                rdata[BIT_CONT]   = cont_q;
                rdata[BIT_POL]    = shd_pol_q;
            end
            REG_PERIOD: rdata = BUS_W'(shd_per_q);
            REG_DUTY:   rdata = BUS_W'(shd_duty_q);
            REG_NONE:   rdata = '0;
        endcase
    end

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE) |-> (!pwm_o && cnt_q == '0));
    p_start_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN) |=> (state_q == CH_RUN));
    p_zero_duty_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_duty_q == '0) |-> !pwm_o);
    p_cnt_in_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < per_eff);
    p_boundary_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == CH_RUN) && ($past(state_q) == CH_RUN) &&
         !($stable(act_per_q) && $stable(act_duty_q) && $stable(act_pol_q)))
        |-> (cnt_q == '0));
    p_commit_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !upd_set) |=> !pend_q);
    p_update_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && upd_set) |=> pend_q);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [NUM_CH-1:0] ch_hit;
    reg_sel_e          sel;
    logic [BUS_W-1:0]  ch_rd [NUM_CH];

    pwm_bank_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
        .addr   (reg_addr),
        .ch_hit (ch_hit),
        .sel    (sel)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwm_bank_chan #(.CNT_W(CNT_W)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (reg_wr && ch_hit[i]),
            .sel   (sel),
            .wdata (reg_wdata),
            .rdata (ch_rd[i]),
            .pwm_o (pwm_out[i])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_hit[i]) reg_rdata = ch_rd[i];
        end
    end

    p_one_channel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_hit));
    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_hit == '0) || (sel == REG_NONE)) |-> (reg_rdata == '0));
endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
    localparam int NCH = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [7:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NCH-1:0]  pwm_out;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [NCH-1:0] v;
        string          tag;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    pwm_bank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: one expected output vector per falling edge while the queue holds items
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.tag, 32'(pwm_out), 32'(e.v));
        end
    end

    task automatic push(input logic [NCH-1:0] v, input string tag);
        exp_t e;
        e.v = v;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(posedge clk);
        #2;
        reg_wr = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Scenario A: reset state, register map, update flag, arm, polarity 1
        do_reset();
        #1;
        chk("R1 outputs low", 32'(pwm_out), 32'h0);
        rd(8'h00, 32'h0, "R1 ctrl0 zero");
        rd(8'h08, 32'h0, "R1 period0 zero");
        wr(8'h08, 32'd5);
        wr(8'h0C, 32'd2);
        wr(8'h00, 32'h124);
        rd(8'h00, 32'h124, "R3 update pending");
        rd(8'h00, 32'h120, "R3 update cleared idle");
        rd(8'h08, 32'd5, "R2 period readback");
        rd(8'h0C, 32'd2, "R2 duty readback");
        chk("R8 idle low", 32'(pwm_out), 32'h0);
        wr(8'h04, 32'hFFFF);
        rd(8'h04, 32'h0, "R2 unmapped offset");
        rd(8'hC0, 32'h0, "R2 beyond last channel");
        wr(8'h00, 32'h121);
        for (int j = 0; j < 10; j++) begin
            if (j > 0) tick();
            push(((j % 5) < 2) ? 6'b000001 : 6'b000000, "R5 R8 R10 pol1 5/2");
        end
        drain();

        // Scenario B: mid-period shadow writes, boundary commit, start sticky, continuous clear
        do_reset();
        wr(8'hA8, 32'd6);
        wr(8'hAC, 32'd3);
        wr(8'hA4 + 8'h00 - 8'h04, 32'h104);
        wr(8'hA0, 32'h101);
        push(6'b100000, "R8 first period cnt0");
        wr(8'hA8, 32'd2);
        push(6'b100000, "R4 old values cnt1");
        wr(8'hAC, 32'd1);
        push(6'b100000, "R4 old values cnt2");
        wr(8'hA0, 32'h104);
        push(6'b000000, "R4 R8 R10 cnt3 running");
        tick(); push(6'b000000, "R4 cnt4");
        tick(); push(6'b000000, "R4 cnt5");
        tick(); push(6'b100000, "R4 new period cnt0");
        tick(); push(6'b000000, "R4 new period cnt1");
        tick(); push(6'b100000, "R4 new period cnt0 again");
        tick(); push(6'b000000, "R4 new period cnt1 again");
        drain();
        rd(8'hA0, 32'h101, "R8 start sticky R3 cleared");

        // Scenario C: update request on the commit edge, polarity 0 pattern
        do_reset();
        wr(8'h08, 32'd4);
        wr(8'h0C, 32'd1);
        wr(8'h00, 32'h024);
        wr(8'h00, 32'h021);
        push(6'b000000, "R5 pol0 cnt0");
        wr(8'h08, 32'd2);
        push(6'b000001, "R5 pol0 cnt1");
        wr(8'h0C, 32'd2);
        push(6'b000001, "R5 pol0 cnt2");
        wr(8'h00, 32'h124);
        push(6'b000001, "R5 pol0 cnt3");
        wr(8'h00, 32'h124);
        push(6'b000001, "R9 commit with update collision");
        wr(8'h0C, 32'd0);
        push(6'b000001, "R9 pending kept cnt1");
        tick(); push(6'b000000, "R9 later commit duty0");
        tick(); push(6'b000000, "R6 R9 duty0 stays low");
        drain();
        rd(8'h00, 32'h121, "R9 update cleared after later commit");

        // Scenario D: duty beyond period, zero period, zero duty
        do_reset();
        wr(8'h48, 32'd3);  wr(8'h4C, 32'd7); wr(8'h40, 32'h104); wr(8'h40, 32'h101);
        wr(8'h68, 32'd0);  wr(8'h6C, 32'd1); wr(8'h60, 32'h104); wr(8'h60, 32'h101);
        wr(8'h88, 32'd4);  wr(8'h8C, 32'd0); wr(8'h80, 32'h004); wr(8'h80, 32'h001);
        wr(8'h08, 32'd3);  wr(8'h0C, 32'd0); wr(8'h00, 32'h104); wr(8'h00, 32'h101);
        for (int j = 0; j < 8; j++) begin
            push(6'b001100, "R6 R7 full duty zero period zero duty");
            tick();
        end
        drain();
        rd(8'h68, 32'h0, "R2 R7 zero period readback");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule